// File: doc/BRIEF.md
# Constant On-Time Pulse Generator

This block is the digital timing core of a ripple-regulated buck converter loop. It watches a single comparator bit that is high while the sensed feedback sits below the active target. When that bit is seen in an idle state, the block issues one high-side pulse. The pulse lasts a programmed number of clock cycles and is followed by an enforced low interval. Choosing the target, the lower of the soft-start ramp and the fixed reference, is done outside the block, along with all analog comparison and the power stage.

The on-time count is supplied from outside. Software or a feed-forward circuit scales it inversely with input voltage, so the switching frequency stays roughly constant across line changes. The minimum off-time count leaves room for the low-side current sample. The block marks the last cycle of that interval with a strobe. Under a sustained request, such as after a load step, pulses repeat back to back at one pulse per (on-time + off-time) cycles. A pre-charged output above target causes no switching at all, so it is never pulled down.

Top module: `cot_pulse_gen`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, `pwm` and `sample_stb` are 0.
- R2: With `en` high and the block idle, a rising clock edge that samples `fb_low` = 1 raises `pwm` from that edge on, so it is high one cycle after the request is applied.
- R3: Each pulse keeps `pwm` high for exactly `on_len` cycles; an `on_len` of 0 gives a one-cycle pulse.
- R4: After each pulse `pwm` stays low for at least `off_len` cycles (0 counts as 1). With `fb_low` held high, pulses repeat with a period of exactly max(`on_len`,1) + max(`off_len`,1) cycles.
- R5: `sample_stb` is high for one cycle, on the last cycle of each minimum off interval, and `pwm` is low in that cycle.
- R6: While `fb_low` stays 0 (pre-biased output above target), `pwm` never rises.
- R7: A one-cycle `fb_low` request that arrives during the on-time, or during the off interval other than its last cycle, is dropped and not stored; it produces no later pulse.
- R8: Lowering `en` drives `pwm` low in the same cycle and abandons the pulse. While `en` is low, no pulse starts. After `en` returns high, a request starts a fresh full-length pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the output low |
| fb_low | input | 1 | Comparator result: feedback below target |
| on_len | input | CNT_W | On-time in clock cycles |
| off_len | input | CNT_W | Minimum off-time in clock cycles |
| pwm | output | 1 | High-side pulse request |
| sample_stb | output | 1 | Last cycle of the minimum off interval |

## Verification
A wrong phase or a miscounted interval shows up at `pwm` within one switching period. It appears as a pulse that is a cycle too long or too short, or as a gap that differs from the programmed off-time, so the bench compares every cycle of a free-running pattern against the arithmetic period for each on/off pair in a small sweep. A request latched where it should have been dropped shows up as an extra pulse within a few cycles of the off interval ending. A disable that fails to clear the phase shows up as a stray pulse right after re-enable. A misplaced strobe shows up against the same per-cycle pattern.

// File: rtl/cot_pkg.sv
package cot_pkg;

    // Phase of the modulator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } cot_phase_e;

    // Control output towards the interval timer
    typedef struct packed {
        logic       load;
        cot_phase_e phase;
    } cot_ctrl_s;

endpackage

// File: rtl/cot_interval_timer.sv
module cot_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/cot_phase_ctrl.sv
module cot_phase_ctrl
    import cot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fb_low,
    input  logic             expired,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output cot_phase_e       phase
);

    cot_phase_e       nxt;
    logic [CNT_W-1:0] on_ld;
    logic [CNT_W-1:0] off_ld;

    // A zero length is clamped to one cycle; the timer counts down to zero.
    assign on_ld  = (on_len  == '0) ? '0 : on_len  - CNT_W'(1);
    assign off_ld = (off_len == '0) ? '0 : off_len - CNT_W'(1);

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        if (!en) begin
            nxt = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (fb_low) begin
                        nxt      = PH_ON;
                        load     = 1'b1;
                        load_val = on_ld;
                    end
                end
                PH_ON: begin
                    if (expired) begin
                        nxt      = PH_OFF;
                        load     = 1'b1;
                        load_val = off_ld;
                    end
                end
                PH_OFF: begin
                    if (expired) begin
                        if (fb_low) begin
                            nxt      = PH_ON;
                            load     = 1'b1;
                            load_val = on_ld;
                        end else begin
                            nxt = PH_IDLE;
                        end
                    end
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    // R6
    no_req_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_ON && !fb_low) |=> (phase != PH_ON));

    // R3
    on_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ON && !expired && en) |=> (phase == PH_ON));

    // R4
    off_after_on_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ON && expired && en) |=> (phase == PH_OFF));

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase == PH_IDLE));

endmodule

// File: rtl/cot_pulse_gen.sv
module cot_pulse_gen
    import cot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fb_low,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             pwm,
    output logic             sample_stb
);

    cot_ctrl_s        ctrl;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    cot_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fb_low   (fb_low),
        .expired  (expired),
        .on_len   (on_len),
        .off_len  (off_len),
        .load     (ctrl.load),
        .load_val (load_val),
        .phase    (ctrl.phase)
    );

    cot_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl.load),
        .load_val (load_val),
        .expired  (expired)
    );

    assign pwm        = en && (ctrl.phase == PH_ON);
    assign sample_stb = en && (ctrl.phase == PH_OFF) && expired;

    // R5
    stb_low_side_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> !pwm);

endmodule

// File: tb/cot_pulse_gen_tb.sv
module cot_pulse_gen_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic fb_low = 1'b0;
    logic [W-1:0] on_len = '0;
    logic [W-1:0] off_len = '0;
    logic pwm;
    logic sample_stb;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cot_pulse_gen #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .fb_low(fb_low),
        .on_len(on_len), .off_len(off_len),
        .pwm(pwm), .sample_stb(sample_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Return to idle, program lengths, then hold a request for n cycles
    task automatic run_cfg(input int t, input int o, input int n);
        int h, l, p, bad_p, bad_s, exp_p, exp_s;
        h = (t == 0) ? 1 : t;
        l = (o == 0) ? 1 : o;
        p = h + l;
        bad_p = 0;
        bad_s = 0;
        @(negedge clk);
        en = 1'b0; fb_low = 1'b0;
        on_len = W'(t); off_len = W'(o);
        @(negedge clk);
        en = 1'b1; fb_low = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            exp_p = (((i - 1) % p) < h) ? 1 : 0;
            exp_s = (((i - 1) % p) == p - 1) ? 1 : 0;
            if (i == 1) chk(pwm == 1'b1, "R2 start latency", int'(pwm), 1);
            if (int'(pwm) != exp_p) bad_p++;
            if (int'(sample_stb) != exp_s) bad_s++;
        end
        chk(bad_p == 0, $sformatf("R3/R4 pattern on=%0d off=%0d mismatches", t, o), bad_p, 0);
        chk(bad_s == 0, $sformatf("R5 strobe on=%0d off=%0d mismatches", t, o), bad_s, 0);
        fb_low = 1'b0;
    endtask

    initial begin
        int highs;
        bit seen;
        // R1: reset
        repeat (3) @(negedge clk);
        en = 1'b1; fb_low = 1'b1;
        @(negedge clk);
        chk(pwm == 1'b0 && sample_stb == 1'b0, "R1 during reset", int'(pwm), 0);
        fb_low = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(pwm == 1'b0 && sample_stb == 1'b0, "R1 after reset", int'(pwm), 0);

        // R2 R3 R4 R5: sweep of lengths, including zero
        for (int t = 0; t <= 5; t++)
            for (int o = 0; o <= 4; o++)
                run_cfg(t, o, 40);

        // R6: pre-biased output, no request
        @(negedge clk);
        en = 1'b0; fb_low = 1'b0; on_len = 3; off_len = 2;
        @(negedge clk);
        en = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pwm) seen = 1'b1;
        end
        chk(!seen, "R6 no pulse while above target", int'(seen), 0);

        // R6: single request afterwards gives one full pulse
        fb_low = 1'b1;
        highs = 0;
        @(negedge clk);
        fb_low = 1'b0;
        if (pwm) highs++;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
        chk(highs == 3, "R6 single request pulse length", highs, 3);

        // R7: requests during on-time and early off interval are dropped
        on_len = 4; off_len = 3;
        highs = 0;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (pwm) highs++;
            fb_low = (j == 0 || j == 2 || j == 3 || j == 5);
        end
        fb_low = 1'b0;
        chk(highs == 4, "R7 ignored requests high cycles", highs, 4);

        // R8: disable mid-pulse
        @(negedge clk);
        on_len = 6; off_len = 2; fb_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(pwm == 1'b1, "R8 pulse running before disable", int'(pwm), 1);
        en = 1'b0;
        #1;
        chk(pwm == 1'b0, "R8 same-cycle low on disable", int'(pwm), 0);
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pwm) seen = 1'b1;
        end
        chk(!seen, "R8 no pulse while disabled", int'(seen), 0);
        en = 1'b1;
        @(negedge clk);
        fb_low = 1'b0;
        highs = 0;
        if (pwm) highs++;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
        chk(highs == 6, "R8 fresh full pulse after re-enable", highs, 6);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule